// File: doc/BRIEF.md
# Interrupt Acceptance and Priority Arbiter

This block sits beside an execution core and decides which pending event, if any, the core services at an instruction boundary. The core raises a one-cycle boundary strobe between instructions. In that cycle the block looks at its request inputs: restartable faults, trap-type instructions, debug traps and debug faults, a latched non-maskable interrupt, and a level-sampled maskable interrupt. It ranks them by a fixed class order and grants at most one. In the next cycle it reports the winner as a one-hot grant word, an 8-bit vector number and a 2-bit class code.

Only the non-maskable interrupt is remembered between boundaries. It is edge-detected into a pending latch. After it is accepted, new edges are ignored until the core reports that an interrupt return has executed. The other exception requests exist only at the boundary where they are presented. A request that loses arbitration is dropped, and the core is expected to find it again later. The maskable request is a level that the external controller holds until it is served. A strobe marks an instruction that reloaded the stack segment. At the boundary after that instruction, the asynchronous and debug classes are held off, while ordinary faults and trap instructions still go through.

All pins are plain control and status signals. The grant is a one-cycle pulse with no ready and no back-pressure, so the core must take it in the cycle it appears.

Top module: `intr_arbiter`

## Requirements
- R1: A grant appears only in the cycle right after a cycle with `boundary`=1. It lasts exactly one cycle. With `boundary` held at 0, `grant`, `evt_vec`, `evt_class` and `vec_err` stay 0 whatever the requests are.
- R2: At most one `grant` bit is set. The bit positions are 0 fault, 1 trap instruction, 2 debug trap, 3 debug fault, 4 NMI, 5 maskable interrupt. Among the eligible requests, the lowest bit position wins.
- R3: The vector and class follow the winner. A fault gives `fault_vec` with class 1. A trap instruction gives `trap_vec` with class 2. A debug trap gives vector 1 with class 2. A debug fault gives vector 1 with class 1. An NMI gives vector 2 with class 3. A maskable interrupt gives `intr_vec` with class 3. With no grant, the vector and class are 0.
- R4: A fault, trap-instruction or debug request that loses, or that is not presented, is not carried to later boundaries. A pending NMI that loses stays pending and wins a later boundary.
- R5: A rising edge on `nmi_in` sets an NMI pending latch when NMI is not blocked. The latch holds until the NMI is granted.
- R6: Granting an NMI blocks NMI. Edges that arrive while NMI is blocked are discarded. A cycle with `iret_done`=1 removes the block, and later edges are accepted again.
- R7: The maskable interrupt is eligible only when `if_flag`=1 at the boundary. It is sampled as a level and never latched.
- R8: `ss_load` arms a shadow that covers the next boundary. The boundary in the same cycle as `ss_load` also counts as that next boundary. Under the shadow, bits 2 to 5 are ineligible, while faults and trap instructions can still be granted. A pending NMI survives the shadow. One boundary consumes the shadow.
- R9: Take the case where the maskable interrupt would otherwise be eligible (request high, `if_flag`=1, no shadow) and `intr_vec` is below 32. The request is then not eligible, and `vec_err` pulses in the grant cycle. A vector of 32 to 255 is accepted.
- R10: After reset, all outputs are 0, no NMI is pending or blocked, and no shadow is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction-boundary strobe |
| fault_req | input | 1 | Non-debug fault request |
| fault_vec | input | 8 | Vector of the fault |
| trap_req | input | 1 | Trap-instruction request |
| trap_vec | input | 8 | Vector of the trap instruction |
| dbg_trap_req | input | 1 | Debug trap for the current instruction |
| dbg_fault_req | input | 1 | Debug fault for the next instruction |
| nmi_in | input | 1 | Non-maskable interrupt line, edge-detected |
| intr_req | input | 1 | Maskable interrupt request level |
| intr_vec | input | 8 | Vector supplied by the external controller |
| if_flag | input | 1 | Interrupt-enable flag |
| ss_load | input | 1 | Marks an instruction that loaded the stack segment |
| iret_done | input | 1 | Interrupt return executed |
| grant | output | 6 | One-hot winner, one cycle after the boundary |
| evt_vec | output | 8 | Vector of the winner |
| evt_class | output | 2 | 0 none, 1 fault, 2 trap, 3 interrupt |
| vec_err | output | 1 | Maskable vector out of range |

## Verification
Two functions can fall on the same boundary: the stack-load shadow and the priority pick. A shadow can hide a high-ranked debug or NMI request while a lower fault or trap instruction still wins. An armed shadow can also meet a bad maskable vector, which must then raise no error. The bench provokes this by sweeping all 256 combinations of six requests, shadow and enable, with shifting vectors. It judges each boundary against an arithmetic model that tracks NMI pending and block state on its own. A second overlap is an NMI edge against the block and its release, and directed sequences check that edges are ignored and accepted on the correct side of the return strobe.

// File: rtl/intarb_pkg.sv
package intarb_pkg;
  localparam int NSRC       = 6;
  localparam int SRC_FAULT  = 0;
  localparam int SRC_TRAP   = 1;
  localparam int SRC_DTRAP  = 2;
  localparam int SRC_DFAULT = 3;
  localparam int SRC_NMI    = 4;
  localparam int SRC_INTR   = 5;

  // sources held off by the stack-load shadow
  localparam logic [NSRC-1:0] SHADOW_MASK = 6'b111100;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_FAULT = 2'd1,
    CLS_TRAP  = 2'd2,
    CLS_INTR  = 2'd3
  } evt_class_e;

  function automatic evt_class_e class_of(input int src);
    case (src)
      SRC_FAULT, SRC_DFAULT: class_of = CLS_FAULT;
      SRC_TRAP,  SRC_DTRAP:  class_of = CLS_TRAP;
      default:               class_of = CLS_INTR;
    endcase
  endfunction
endpackage

// File: rtl/intarb_nmi_track.sv
module intarb_nmi_track (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic iret_done,
  input  logic take,
  output logic pending
);
  logic prev_q, pend_q, block_q;
  logic rise;

  assign rise    = nmi_in & ~prev_q;
  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
      block_q <= 1'b0;
    end else begin
      prev_q <= nmi_in;
      if (take) begin
        pend_q  <= 1'b0;
        block_q <= 1'b1;
      end else begin
        if (rise && !block_q) pend_q <= 1'b1;
        if (iret_done)        block_q <= 1'b0;
      end
    end
  end

  // R6: an NMI is never taken while blocked
  a_r6_no_take_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !block_q);
  // R6: taking an NMI installs the block
  a_r6_block_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> block_q);
  // R5: pending holds until taken
  a_r5_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take) |=> pend_q);
endmodule

// File: rtl/intarb_gate.sv
module intarb_gate
  import intarb_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int MIN_EXT_VEC = 32
) (
  input  logic [NSRC-1:0]  raw,
  input  logic             shadow,
  input  logic             if_flag,
  input  logic [VEC_W-1:0] intr_vec,
  output logic [NSRC-1:0]  elig,
  output logic             vec_bad
);
  logic [NSRC-1:0] unshadowed;
  logic in_range, intr_ok;

  assign unshadowed = raw & ~({NSRC{shadow}} & SHADOW_MASK);
  assign in_range   = intr_vec >= VEC_W'(MIN_EXT_VEC);
  assign intr_ok    = unshadowed[SRC_INTR] & if_flag;
  assign vec_bad    = intr_ok & ~in_range;

  always_comb begin
    elig           = unshadowed;
    elig[SRC_INTR] = intr_ok & in_range;
  end
endmodule

// File: rtl/intarb_pick.sv
module intarb_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rank
      if (g == 0) begin : g_top
        assign gnt[g] = req[g];
      end else begin : g_low
        assign gnt[g] = req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intarb_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int MIN_EXT_VEC = 32,
  parameter int DBG_VEC     = 1,
  parameter int NMI_VEC     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             fault_req,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic             trap_req,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic             dbg_trap_req,
  input  logic             dbg_fault_req,
  input  logic             nmi_in,
  input  logic             intr_req,
  input  logic [VEC_W-1:0] intr_vec,
  input  logic             if_flag,
  input  logic             ss_load,
  input  logic             iret_done,
  output logic [NSRC-1:0]  grant,
  output logic [VEC_W-1:0] evt_vec,
  output logic [1:0]       evt_class,
  output logic             vec_err
);
  logic             nmi_pend, nmi_take;
  logic             shadow_q, shadow_eff;
  logic [NSRC-1:0]  raw, elig, pick;
  logic             vec_bad;
  logic [VEC_W-1:0] src_vec [NSRC];
  logic [VEC_W-1:0] vec_n;
  evt_class_e       cls_n;

  logic [NSRC-1:0]  grant_q;
  logic [VEC_W-1:0] vec_q;
  evt_class_e       cls_q;
  logic             err_q;

  // shadow: armed by ss_load, consumed by one boundary
  always_ff @(posedge clk) begin
    if (!rst_n)        shadow_q <= 1'b0;
    else if (boundary) shadow_q <= 1'b0;
    else if (ss_load)  shadow_q <= 1'b1;
  end
  assign shadow_eff = shadow_q | ss_load;

  always_comb begin
    raw             = '0;
    raw[SRC_FAULT]  = fault_req;
    raw[SRC_TRAP]   = trap_req;
    raw[SRC_DTRAP]  = dbg_trap_req;
    raw[SRC_DFAULT] = dbg_fault_req;
    raw[SRC_NMI]    = nmi_pend;
    raw[SRC_INTR]   = intr_req;
  end

  intarb_nmi_track u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_in   (nmi_in),
    .iret_done(iret_done),
    .take     (nmi_take),
    .pending  (nmi_pend)
  );

  intarb_gate #(.VEC_W(VEC_W), .MIN_EXT_VEC(MIN_EXT_VEC)) u_gate (
    .raw     (raw),
    .shadow  (shadow_eff),
    .if_flag (if_flag),
    .intr_vec(intr_vec),
    .elig    (elig),
    .vec_bad (vec_bad)
  );

  intarb_pick #(.N(NSRC)) u_pick (
    .req(elig),
    .gnt(pick)
  );

  assign nmi_take = boundary & pick[SRC_NMI];

  always_comb begin
    src_vec[SRC_FAULT]  = fault_vec;
    src_vec[SRC_TRAP]   = trap_vec;
    src_vec[SRC_DTRAP]  = VEC_W'(DBG_VEC);
    src_vec[SRC_DFAULT] = VEC_W'(DBG_VEC);
    src_vec[SRC_NMI]    = VEC_W'(NMI_VEC);
    src_vec[SRC_INTR]   = intr_vec;
    vec_n = '0;
    cls_n = CLS_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (pick[i]) begin
        vec_n = src_vec[i];
        cls_n = class_of(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !boundary) begin
      grant_q <= '0;
      vec_q   <= '0;
      cls_q   <= CLS_NONE;
      err_q   <= 1'b0;
    end else begin
      grant_q <= pick;
      vec_q   <= vec_n;
      cls_q   <= cls_n;
      err_q   <= vec_bad;
    end
  end

  assign grant     = grant_q;
  assign evt_vec   = vec_q;
  assign evt_class = cls_q;
  assign vec_err   = err_q;

  // R1: grants follow a boundary strobe
  a_r1_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_q) |-> $past(boundary));
  // R2: never more than one winner
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  // R3: NMI reports its fixed vector and interrupt class
  a_r3_nmi_vec: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q[SRC_NMI] |-> (vec_q == VEC_W'(NMI_VEC) && cls_q == CLS_INTR));
  // R7: maskable grant needs the enable flag
  a_r7_if_needed: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q[SRC_INTR] |-> $past(if_flag));
  // R8: shadowed boundary grants no debug or asynchronous event
  a_r8_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && shadow_eff) |=> ((grant_q & SHADOW_MASK) == '0));
  // R9: error excludes a maskable grant and implies a low vector
  a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!grant_q[SRC_INTR] && $past(intr_vec) < VEC_W'(MIN_EXT_VEC)));
endmodule

// File: tb/test_intr_arbiter.sv
`timescale 1ns/1ps
module test_intr_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boundary = 0, fault_req = 0, trap_req = 0, dbg_trap_req = 0;
  logic       dbg_fault_req = 0, nmi_in = 0, intr_req = 0, if_flag = 0;
  logic       ss_load = 0, iret_done = 0;
  logic [7:0] fault_vec = 0, trap_vec = 0, intr_vec = 0;
  logic [5:0] grant;
  logic [7:0] evt_vec;
  logic [1:0] evt_class;
  logic       vec_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit pend_m = 0, block_m = 0;

  always #2.5 clk = ~clk;

  intr_arbiter i_intr_arbiter (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .fault_req(fault_req), .fault_vec(fault_vec),
    .trap_req(trap_req), .trap_vec(trap_vec),
    .dbg_trap_req(dbg_trap_req), .dbg_fault_req(dbg_fault_req),
    .nmi_in(nmi_in), .intr_req(intr_req), .intr_vec(intr_vec),
    .if_flag(if_flag), .ss_load(ss_load), .iret_done(iret_done),
    .grant(grant), .evt_vec(evt_vec), .evt_class(evt_class), .vec_err(vec_err)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare all outputs against an expected tuple
  task automatic expect_out(input string req, input logic [5:0] g, input logic [7:0] v,
                            input logic [1:0] c, input logic e);
    int act, exp;
    act = {grant, evt_vec, evt_class, vec_err};
    exp = {g, v, c, e};
    check(act == exp, req, act, exp);
  endtask

  task automatic clear_reqs();
    fault_req = 0; trap_req = 0; dbg_trap_req = 0; dbg_fault_req = 0; intr_req = 0;
  endtask

  task automatic nmi_edge();
    nmi_in = 1; tick(); nmi_in = 0; tick();
    if (!block_m) pend_m = 1;
  endtask

  task automatic iret_pulse();
    iret_done = 1; tick(); iret_done = 0;
    block_m = 0;
  endtask

  task automatic strobe();
    boundary = 1; tick(); boundary = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rst_n = 1;
    tick();
    // R10: reset state
    expect_out("R10 reset", 6'h0, 8'h0, 2'd0, 1'b0);

    // R1: requests without boundary give nothing
    fault_req = 1; trap_req = 1; intr_req = 1; if_flag = 1; intr_vec = 8'd40;
    tick(); tick(); tick();
    expect_out("R1 no boundary", 6'h0, 8'h0, 2'd0, 1'b0);
    clear_reqs();

    // R9: vector range edges
    intr_req = 1; if_flag = 1; intr_vec = 8'd31; strobe();
    expect_out("R9 vec31", 6'h0, 8'h0, 2'd0, 1'b1);
    intr_vec = 8'd32; strobe();
    expect_out("R9 vec32", 6'h20, 8'd32, 2'd3, 1'b0);
    intr_vec = 8'd255; strobe();
    expect_out("R3 vec255", 6'h20, 8'd255, 2'd3, 1'b0);
    tick();
    expect_out("R1 one cycle", 6'h0, 8'h0, 2'd0, 1'b0);
    clear_reqs();

    // R5/R6: NMI block and release
    nmi_edge(); strobe();
    expect_out("R5 nmi granted", 6'h10, 8'd2, 2'd3, 1'b0);
    pend_m = 0; block_m = 1;
    nmi_edge(); strobe();
    expect_out("R6 edge while blocked", 6'h0, 8'h0, 2'd0, 1'b0);
    iret_pulse(); strobe();
    expect_out("R6 blocked edge discarded", 6'h0, 8'h0, 2'd0, 1'b0);
    nmi_edge(); tick(); tick(); strobe();
    expect_out("R5 nmi after iret", 6'h10, 8'd2, 2'd3, 1'b0);
    pend_m = 0; block_m = 1;

    // R4: losing exception dropped, pending NMI kept
    iret_pulse();
    fault_req = 1; fault_vec = 8'd14; dbg_trap_req = 1; strobe(); clear_reqs();
    expect_out("R4 fault wins", 6'h01, 8'd14, 2'd1, 1'b0);
    strobe();
    expect_out("R4 debug trap dropped", 6'h0, 8'h0, 2'd0, 1'b0);
    nmi_edge();
    trap_req = 1; trap_vec = 8'd3; strobe(); clear_reqs();
    expect_out("R4 trap beats nmi", 6'h02, 8'd3, 2'd2, 1'b0);
    strobe();
    expect_out("R4 nmi kept", 6'h10, 8'd2, 2'd3, 1'b0);
    pend_m = 0; block_m = 1;

    // R7: enable flag, not latched
    intr_req = 1; intr_vec = 8'd64; if_flag = 0; strobe();
    expect_out("R7 if clear", 6'h0, 8'h0, 2'd0, 1'b0);
    intr_req = 0; if_flag = 1; strobe();
    expect_out("R7 not latched", 6'h0, 8'h0, 2'd0, 1'b0);

    // R8: shadow consumed by one boundary, same-cycle form
    ss_load = 1; tick(); ss_load = 0;
    intr_req = 1; dbg_fault_req = 1; strobe();
    expect_out("R8 shadow blocks", 6'h0, 8'h0, 2'd0, 1'b0);
    strobe();
    expect_out("R8 shadow consumed", 6'h08, 8'd1, 2'd1, 1'b0);
    ss_load = 1; fault_req = 1; fault_vec = 8'd13; strobe(); ss_load = 0;
    expect_out("R8 fault under shadow", 6'h01, 8'd13, 2'd1, 1'b0);
    clear_reqs();

    // R2/R3/R8/R9: sweep of requests, shadow and enable
    for (int idx = 0; idx < 256; idx++) begin
      logic [5:0] bits, elig, eg;
      logic [7:0] ev;
      logic [1:0] ec;
      logic       sh, ie, ee;
      int         win;
      bits = idx[5:0]; sh = idx[6]; ie = idx[7];
      iret_pulse();
      if (bits[4]) nmi_edge();
      if (sh) begin ss_load = 1; tick(); ss_load = 0; end
      fault_req = bits[0]; trap_req = bits[1]; dbg_trap_req = bits[2];
      dbg_fault_req = bits[3]; intr_req = bits[5]; if_flag = ie;
      fault_vec = 8'(idx); trap_vec = 8'(idx + 100);
      intr_vec = 8'((idx * 7 + 25) % 256);
      elig[0] = bits[0];
      elig[1] = bits[1];
      elig[2] = bits[2] & ~sh;
      elig[3] = bits[3] & ~sh;
      elig[4] = pend_m & ~sh;
      elig[5] = bits[5] & ie & ~sh & (intr_vec >= 32);
      ee = bits[5] & ie & ~sh & (intr_vec < 32);
      win = -1;
      for (int k = 5; k >= 0; k--) if (elig[k]) win = k;
      eg = 0; ev = 0; ec = 0;
      if (win >= 0) begin
        eg[win] = 1'b1;
        case (win)
          0: begin ev = fault_vec; ec = 1; end
          1: begin ev = trap_vec;  ec = 2; end
          2: begin ev = 1;         ec = 2; end
          3: begin ev = 1;         ec = 1; end
          4: begin ev = 2;         ec = 3; end
          default: begin ev = intr_vec; ec = 3; end
        endcase
      end
      strobe();
      expect_out("R2 sweep", eg, ev, ec, ee);
      if (win == 4) begin pend_m = 0; block_m = 1; end
      clear_reqs();
      tick();
      expect_out("R1 sweep idle", 6'h0, 8'h0, 2'd0, 1'b0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule